// File: doc/BRIEF.md
# Instruction-Set Switch Target Unit

This unit produces the landing address when a core hops between its native 64-bit instruction set and an older 32-bit segmented instruction set. A request names one of three moves. The first is a jump into native mode with an immediate displacement. The second is a jump into native mode through a register value. The third is a branch back into legacy mode through a 64-bit branch register. Together with the request the unit receives the code-segment base and limit, a privilege-violation flag, a pending-numeric-exception flag and the current privilege level.

The next clock edge registers the new instruction pointer, the legacy EIP, the mode bit and a fault code, and raises a one-cycle valid strobe. Jumps into native mode are offset from the segment base. They are forced onto a 16-byte boundary and confined to the low 4 GB. A pending numeric exception cancels such a jump. Branches into legacy mode always complete. A protection problem with the legacy target is reported as a fault against that target, so it does not block the switch. A request whose direction does not fit the current mode is refused.

Top module: `isa_xfer_target`

## Requirements
- R1: A valid request with kind 0 (direct native jump), made while in legacy mode (mode=1) with no pending numeric exception, yields new_ip[31:0] = (displacement + cs_base) mod 2^32 with bits 3:0 cleared, new_ip[63:32]=0, mode=0 and fault=0.
- R2: Kind 1 (indirect native jump) behaves as in R1, except that reg_in is used in place of the displacement.
- R3: Every completed native jump lands on a 16-byte boundary, so new_ip[3:0]=0.
- R4: When op16=1, the low 16 bits of the displacement or register are zero-extended before the base is added. When op16=0, all 32 bits are used. The sum wraps modulo 2^32.
- R5: A native jump made while fp_pending=1 is nullified. fault=1, and new_ip, eip and mode keep their previous values.
- R6: A valid request with kind 2 (legacy branch), made while in native mode, yields new_ip = {32'h0, br_in[31:0]}, eip = (br_in[31:0] - cs_base) mod 2^32 and mode=1.
- R7: On a legacy branch, fault=2 when eip > cs_limit (unsigned) or priv_viol=1, and fault=0 otherwise, which includes the case eip == cs_limit. The mode switch and the address update take place in both cases.
- R8: cpl_out always equals cpl_in. No transition changes it.
- R9: A request whose kind does not match the current mode gives fault=3 and leaves new_ip, eip and mode unchanged. A native kind in native mode, kind 2 in legacy mode, and kind 3 in any mode are such requests.
- R10: out_valid is 1 for exactly the cycle after each valid request and 0 otherwise. Outputs hold between requests. After reset: new_ip=0, eip=0, fault=0, mode=1, out_valid=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_kind | input | 2 | 0 direct native, 1 indirect native, 2 legacy branch, 3 reserved |
| op16 | input | 1 | 16-bit operand size |
| disp_in | input | 32 | Displacement for a direct jump |
| reg_in | input | 32 | Register value for an indirect jump |
| br_in | input | 64 | Branch register for a legacy branch |
| cs_base | input | 32 | Code-segment base |
| cs_limit | input | 32 | Code-segment limit |
| priv_viol | input | 1 | Privilege violation on the legacy target |
| fp_pending | input | 1 | Pending legacy numeric exception |
| cpl_in | input | 2 | Current privilege level |
| cpl_out | output | 2 | Privilege level after the transition |
| out_valid | output | 1 | Result strobe |
| new_ip | output | 64 | Instruction pointer |
| eip | output | 32 | Legacy EIP |
| mode | output | 1 | 1 legacy, 0 native |
| fault | output | 2 | 0 none, 1 floating-point, 2 general protection, 3 illegal operation |

## Verification
The bench targets sums that carry past bit 31. A design that truncated these wrongly would set the upper IP half or wrap to the wrong place. It also targets sums whose low nibble is nonzero, where a missing alignment mask leaves bits 3:0 set. A 16-bit operand with nonzero upper bits shows whether zero-extension happens. EIP equal to the limit, and EIP one above it, catch an off-by-one limit compare. A nullified jump would show a changed IP or mode if the cancel were ignored. Mode-mismatched and reserved requests must leave all state untouched.

// File: rtl/isa_xfer_target.sv
module isa_xfer_target #(
  parameter bit RESET_LEGACY = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic [1:0]  req_kind,
  input  logic        op16,
  input  logic [31:0] disp_in,
  input  logic [31:0] reg_in,
  input  logic [63:0] br_in,
  input  logic [31:0] cs_base,
  input  logic [31:0] cs_limit,
  input  logic        priv_viol,
  input  logic        fp_pending,
  input  logic [1:0]  cpl_in,
  output logic [1:0]  cpl_out,
  output logic        out_valid,
  output logic [63:0] new_ip,
  output logic [31:0] eip,
  output logic        mode,
  output logic [1:0]  fault
);
  localparam logic [1:0] K_DIRECT = 2'd0, K_INDIRECT = 2'd1, K_LEGACY = 2'd2;
  localparam logic [1:0] F_NONE = 2'd0, F_FP = 2'd1, F_GP = 2'd2, F_ILL = 2'd3;

  wire [31:0] src_raw = (req_kind == K_DIRECT) ? disp_in : reg_in;
  wire [31:0] src_ext = op16 ? {16'h0, src_raw[15:0]} : src_raw;
  wire [31:0] nat_sum = src_ext + cs_base;
  wire [31:0] nat_tgt = {nat_sum[31:4], 4'h0};
  wire [31:0] leg_ip  = br_in[31:0];
  wire [31:0] leg_eip = leg_ip - cs_base;
  wire        leg_gp  = (leg_eip > cs_limit) || priv_viol;
  wire        to_nat  = (req_kind == K_DIRECT) || (req_kind == K_INDIRECT);
  wire        to_leg  = (req_kind == K_LEGACY);
  wire        unused_hi = ^br_in[63:32];

  assign cpl_out = cpl_in;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      new_ip    <= '0;
      eip       <= '0;
      mode      <= RESET_LEGACY;
      fault     <= F_NONE;
    end else begin
      out_valid <= req_valid;
      if (req_valid) begin
        if (to_nat && mode) begin
          if (fp_pending) begin
            fault <= F_FP;
          end else begin
            new_ip <= {32'h0, nat_tgt};
            mode   <= 1'b0;
            fault  <= F_NONE;
          end
        end else if (to_leg && !mode) begin
          new_ip <= {32'h0, leg_ip};
          eip    <= leg_eip;
          mode   <= 1'b1;
          fault  <= leg_gp ? F_GP : F_NONE;
        end else begin
          fault <= F_ILL;
        end
      end
    end
  end

  assert_upper_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> new_ip[63:32] == 32'h0);
  assert_aligned_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && fault == F_NONE && !mode) |-> new_ip[3:0] == 4'h0);
  assert_nullify_keeps_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && to_nat && mode && fp_pending) |=> (fault == F_FP && mode && $stable(new_ip) && $stable(eip)));
  assert_eip_rel_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && to_leg && !mode) |=> (mode && eip == new_ip[31:0] - $past(cs_base)));
  assert_gp_switches_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && fault == F_GP) |-> mode);
  assert_illegal_keeps_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !(to_nat && mode) && !(to_leg && !mode)) |=>
      (fault == F_ILL && $stable(new_ip) && $stable(eip) && $stable(mode)));
  assert_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !out_valid);
endmodule

// File: tb/isa_xfer_target_bench.sv
`timescale 1ns/1ps
module isa_xfer_target_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, op16 = 1'b0, priv_viol = 1'b0, fp_pending = 1'b0;
  logic [1:0] req_kind = '0, cpl_in = '0;
  logic [31:0] disp_in = '0, reg_in = '0, cs_base = '0, cs_limit = '0;
  logic [63:0] br_in = '0;
  logic [1:0] cpl_out, fault;
  logic out_valid, mode;
  logic [63:0] new_ip;
  logic [31:0] eip;

  int vectors = 0, errors = 0;
  logic [63:0] m_ip;
  logic [31:0] m_eip;
  logic m_mode;
  logic [1:0] m_fault;

  always #2.5 clk = ~clk;

  isa_xfer_target u_isa_xfer_target (.*);

  function automatic logic [31:0] nat_target(logic [31:0] v, logic w16, logic [31:0] b);
    logic [31:0] e, s;
    e = w16 ? {16'h0, v[15:0]} : v;
    s = e + b;
    return s & 32'hFFFF_FFF0;
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic string tag_of(logic [1:0] k);
    if (k == 2'd0) return "R1";
    if (k == 2'd1) return "R2";
    if (k == 2'd2) return "R6";
    return "R9";
  endfunction

  task automatic apply(logic [1:0] k, logic w16, logic [31:0] d, logic [31:0] r,
                       logic [63:0] br, logic [31:0] b, logic [31:0] lim, logic pv, logic fp);
    string t;
    logic [31:0] le;
    @(negedge clk);
    req_valid = 1'b1; req_kind = k; op16 = w16; disp_in = d; reg_in = r;
    br_in = br; cs_base = b; cs_limit = lim; priv_viol = pv; fp_pending = fp;
    cpl_in = 2'($urandom);
    #1 chk("R8 cpl", {62'h0, cpl_out}, {62'h0, cpl_in});
    t = tag_of(k);
    if (k < 2 && m_mode) begin
      if (fp) begin m_fault = 2'd1; t = "R5"; end
      else begin
        m_ip = {32'h0, nat_target(k == 0 ? d : r, w16, b)};
        m_mode = 1'b0; m_fault = 2'd0;
      end
    end else if (k == 2 && !m_mode) begin
      le = br[31:0] - b;
      m_ip = {32'h0, br[31:0]}; m_eip = le; m_mode = 1'b1;
      m_fault = (le > lim || pv) ? 2'd2 : 2'd0;
      if (m_fault == 2'd2) t = "R7";
    end else begin
      m_fault = 2'd3; t = "R9";
    end
    @(negedge clk);
    req_valid = 1'b0;
    chk({t, " ip"}, new_ip, m_ip);
    chk({t, " eip"}, {32'h0, eip}, {32'h0, m_eip});
    chk({t, " mode"}, {63'h0, mode}, {63'h0, m_mode});
    chk({t, " fault"}, {62'h0, fault}, {62'h0, m_fault});
    chk("R10 strobe", {63'h0, out_valid}, 64'h1);
    @(negedge clk);
    chk("R10 strobe idle", {63'h0, out_valid}, 64'h0);
    chk("R10 hold", new_ip, m_ip);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    m_ip = '0; m_eip = '0; m_mode = 1'b1; m_fault = 2'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 reset ip", new_ip, 64'h0);
    chk("R10 reset eip", {32'h0, eip}, 64'h0);
    chk("R10 reset mode", {63'h0, mode}, 64'h1);
    chk("R10 reset fault", {62'h0, fault}, 64'h0);
    chk("R10 reset valid", {63'h0, out_valid}, 64'h0);

    // R9 legacy branch while in legacy mode
    apply(2'd2, 0, 0, 0, 64'h1234, 32'h0, 32'hFFFF_FFFF, 0, 0);
    // R5 nullified native jump
    apply(2'd0, 0, 32'h100, 0, 0, 32'h10, 0, 0, 1);
    // R1 R3 R4 carry wrap and misaligned sum
    apply(2'd0, 0, 32'hFFFF_FFF0, 0, 0, 32'h0000_0027, 0, 0, 0);
    // R9 native jump while native
    apply(2'd1, 0, 0, 32'h40, 0, 0, 0, 0, 0);
    // R7 eip equal to limit: no fault
    apply(2'd2, 0, 0, 0, 64'hDEAD_BEEF_0000_2100, 32'h100, 32'h2000, 0, 0);
    // R4 16-bit zero extension, R2
    apply(2'd1, 1, 0, 32'hABCD_8009, 0, 32'h0000_0003, 0, 0, 0);
    // R7 eip one above limit
    apply(2'd2, 0, 0, 0, 64'h0000_2101, 32'h100, 32'h2000, 0, 0);
    // R4 full 32-bit displacement, R1
    apply(2'd0, 0, 32'h0001_0035, 0, 0, 32'h10, 0, 0, 0);
    // R7 privilege violation, R6 eip wrap
    apply(2'd2, 0, 0, 0, 64'h0000_0010, 32'h20, 32'hFFFF_FFFF, 1, 0);
    // R9 reserved kind
    apply(2'd3, 0, 0, 0, 0, 0, 0, 0, 0);

    for (int i = 0; i < 600; i++) begin
      logic [1:0] k;
      if (($urandom % 10) < 8) k = m_mode ? 2'($urandom % 2) : 2'd2;
      else k = 2'($urandom);
      apply(k, 1'($urandom), $urandom, $urandom, {$urandom, $urandom}, $urandom,
            ($urandom % 2) ? 32'hFFFF_FFFF : $urandom, ($urandom % 8) == 0, ($urandom % 8) == 0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule